// File: doc/BRIEF.md
# Advanced-Load Tracking Table

This block keeps a small fully associative record of floating-point loads issued ahead of possibly conflicting stores. Each record holds a target floating-point register number, the physical byte address of the load and its size in bytes. The load pipeline presents one request per cycle. The request is either an advanced load, one of two kinds of check load, an explicit invalidation by register, or a store. For load requests the table answers in the same cycle with a hit flag and an action, which says whether the pipeline must translate the address and read memory. It also passes through the base-register update request.

Check loads come in two kinds. The keep kind leaves a matching record in place. The clearing kind removes it. A configuration input can force every check to miss. Pages marked non-speculative never receive a record. A deferred advanced load leaves no record behind, and a store removes every record whose byte range it touches. The table has eight slots by default. A register number that is already present reuses its own slot. A new register takes the slot named by a round-robin pointer.

Top module: `aload_track`

## Requirements
- R1: After reset the table holds no records: every check misses, and with no request `lk_hit`, `act_translate`, `act_read` and `base_update` are 0.
- R2: An advanced load (`req_op`=1) with `req_nonspec`=0 and `req_defer`=0 drives `act_translate`=`act_read`=1 and creates a record, so a later check on that register hits.
- R3: An advanced load with `req_nonspec`=1 or `req_defer`=1 removes any record for its register and creates none. With `req_defer`=1 the action is 0, meaning no translation and no read.
- R4: A keep-check (`req_op`=2) that hits gives `lk_hit`=1 and `act_translate`=`act_read`=0, and the record remains.
- R5: A keep-check that misses gives `act_translate`=`act_read`=1. It creates a record unless `req_nonspec`=1.
- R6: A clearing check (`req_op`=3) that hits gives `lk_hit`=1 and action 0, and removes the record. One that misses gives action 1 and creates nothing.
- R7: For any load request, `base_update` equals `req_base_upd`, whether the check hits or misses.
- R8: While `force_miss`=1 every check gives `lk_hit`=0 and behaves as a miss, whatever the table holds.
- R9: An invalidate request (`req_op`=4) removes the record of `req_freg`.
- R10: A store (`req_op`=5) removes every record whose range [addr, addr+size) overlaps [`req_paddr`, `req_paddr`+`req_size`). Ranges that only abut are kept.
- R11: At most one record exists per register. A new load for a present register overwrites that record's address and size.
- R12: When a new register needs a slot, slots are filled in round-robin order from slot 0 after reset. The ninth distinct register evicts the first one written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 none, 1 advanced, 2 keep-check, 3 clearing check, 4 invalidate, 5 store |
| req_freg | input | RW (7) | Target floating-point register |
| req_paddr | input | AW (32) | Physical byte address |
| req_size | input | SW (5) | Access size in bytes |
| req_nonspec | input | 1 | Page has the non-speculative attribute |
| req_defer | input | 1 | Advanced load was deferred |
| req_base_upd | input | 1 | Instruction updates its base register |
| force_miss | input | 1 | Force every check to miss |
| lk_hit | output | 1 | Check found a record |
| act_translate | output | 1 | Pipeline must translate the address |
| act_read | output | 1 | Pipeline must read memory |
| base_update | output | 1 | Base register update to perform |

## Verification
`lk_hit`, `act_translate`, `act_read` and `base_update` are combinational from the current request and the stored records. They are due in the same cycle the request is presented. Table changes become visible only from the next cycle's request. The bench drives each request on the falling edge and samples the outputs one time unit later, before the rising edge. It then lets that edge commit the update and verifies the new table state with a non-allocating check, issued with the non-speculative flag, on the following falling edge.

// File: rtl/aload_pkg.sv
package aload_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ADV     = 3'd1,
    OP_CHK_NC  = 3'd2,
    OP_CHK_CLR = 3'd3,
    OP_INVAL   = 3'd4,
    OP_STORE   = 3'd5
  } aload_op_e;

  // Half-open byte ranges [a_lo,a_hi) and [b_lo,b_hi) share a byte.
  function automatic logic span_overlap(logic [64:0] a_lo, logic [64:0] a_hi,
                                        logic [64:0] b_lo, logic [64:0] b_hi);
    return (a_lo < b_hi) && (b_lo < a_hi);
  endfunction

  // Exclusive end of a range, widened to avoid wrap at the top of memory.
  function automatic logic [64:0] span_end(logic [64:0] lo, logic [64:0] len);
    return lo + len;
  endfunction

endpackage

// File: rtl/aload_slot.sv
module aload_slot #(
  parameter int AW = 32,
  parameter int RW = 7,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          clr,
  input  logic [RW-1:0] w_reg,
  input  logic [AW-1:0] w_addr,
  input  logic [SW-1:0] w_size,
  output logic          q_valid,
  output logic [RW-1:0] q_reg,
  output logic [AW-1:0] q_addr,
  output logic [SW-1:0] q_size
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_reg   <= '0;
      q_addr  <= '0;
      q_size  <= '0;
    end else if (wr) begin
      q_valid <= 1'b1;
      q_reg   <= w_reg;
      q_addr  <= w_addr;
      q_size  <= w_size;
    end else if (clr) begin
      q_valid <= 1'b0;
    end
  end

  AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q_valid && q_reg == $past(w_reg)) else $error("slot write lost"); // R2

endmodule

// File: rtl/aload_rr.sv
module aload_rr #(
  parameter int NENT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  output logic [$clog2(NENT)-1:0] ptr
);

  localparam int IW = $clog2(NENT);
  localparam logic [IW-1:0] LAST = IW'(NENT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (step)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST) else $error("pointer out of range"); // R12
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr)) else $error("pointer moved"); // R12

endmodule

// File: rtl/aload_track.sv
module aload_track
  import aload_pkg::*;
#(
  parameter int NENT = 8,
  parameter int AW   = 32,
  parameter int RW   = 7,
  parameter int SW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [RW-1:0] req_freg,
  input  logic [AW-1:0] req_paddr,
  input  logic [SW-1:0] req_size,
  input  logic          req_nonspec,
  input  logic          req_defer,
  input  logic          req_base_upd,
  input  logic          force_miss,
  output logic          lk_hit,
  output logic          act_translate,
  output logic          act_read,
  output logic          base_update
);

  localparam int IW = $clog2(NENT);

  aload_op_e op;
  assign op = aload_op_e'(req_op);

  // Slot state
  logic [NENT-1:0] slot_v;
  logic [RW-1:0]   slot_reg  [NENT];
  logic [AW-1:0]   slot_addr [NENT];
  logic [SW-1:0]   slot_size [NENT];

  // Named internal events
  logic            is_chk, is_load, store_go;
  logic            any_match, alloc_en, new_alloc, kill_reg, act_go, clr_hit;
  logic [NENT-1:0] reg_match, store_ovl, wsel, slot_wr, slot_clr;
  logic [IW-1:0]   match_idx, rr_ptr;
  logic [64:0]     st_lo, st_hi;

  assign is_chk   = (op == OP_CHK_NC) || (op == OP_CHK_CLR);
  assign is_load  = is_chk || (op == OP_ADV);
  assign store_go = req_valid && (op == OP_STORE);
  assign st_lo    = 65'(req_paddr);
  assign st_hi    = span_end(st_lo, 65'(req_size));

  for (genvar i = 0; i < NENT; i++) begin : g_slot
    logic [64:0] e_lo, e_hi;
    assign e_lo = 65'(slot_addr[i]);
    assign e_hi = span_end(e_lo, 65'(slot_size[i]));
    assign reg_match[i] = slot_v[i] && (slot_reg[i] == req_freg);
    assign store_ovl[i] = slot_v[i] && span_overlap(e_lo, e_hi, st_lo, st_hi);
    assign slot_wr[i]   = alloc_en && wsel[i];
    assign slot_clr[i]  = (kill_reg && reg_match[i]) || (store_go && store_ovl[i]);

    aload_slot #(.AW(AW), .RW(RW), .SW(SW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (slot_wr[i]),
      .clr    (slot_clr[i]),
      .w_reg  (req_freg),
      .w_addr (req_paddr),
      .w_size (req_size),
      .q_valid(slot_v[i]),
      .q_reg  (slot_reg[i]),
      .q_addr (slot_addr[i]),
      .q_size (slot_size[i])
    );
  end

  assign any_match = |reg_match;

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < NENT; i++)
      if (reg_match[i]) match_idx = IW'(i);
  end

  // Lookup and action
  assign lk_hit   = req_valid && is_chk && !force_miss && any_match;
  assign clr_hit  = lk_hit && (op == OP_CHK_CLR);
  assign act_go   = req_valid && is_load && !lk_hit && !((op == OP_ADV) && req_defer);
  assign act_translate = act_go;
  assign act_read      = act_go;
  assign base_update   = req_valid && is_load && req_base_upd;

  // Table update
  assign kill_reg  = req_valid && ((op == OP_ADV) || (op == OP_CHK_CLR) || (op == OP_INVAL));
  assign alloc_en  = req_valid && !req_nonspec &&
                     (((op == OP_ADV) && !req_defer) || ((op == OP_CHK_NC) && !lk_hit));
  assign wsel      = any_match ? reg_match : (NENT'(1) << rr_ptr);
  assign new_alloc = alloc_en && !any_match;

  aload_rr #(.NENT(NENT)) u_rr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (new_alloc),
    .ptr  (rr_ptr)
  );

  AST_FORCE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    force_miss |-> !lk_hit) else $error("forced miss ignored"); // R8
  AST_HIT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !act_translate && !act_read) else $error("hit still loads"); // R4
  AST_ONE_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reg_match) <= 1) else $error("duplicate register"); // R11
  AST_NONSPEC_NOALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_nonspec) |-> !alloc_en) else $error("nonspec allocated"); // R3
  AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !slot_v[$past(match_idx)]) else $error("clear hit kept record"); // R6
  AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |=> ((slot_v & $past(store_ovl)) == '0)) else $error("store left record"); // R10
  AST_BASE_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_chk && req_base_upd) |-> base_update) else $error("base update dropped"); // R7

endmodule

// File: tb/tb_aload_track.sv
module tb_aload_track;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_nonspec, req_defer, req_base_upd, force_miss;
  logic [2:0]  req_op;
  logic [6:0]  req_freg;
  logic [31:0] req_paddr;
  logic [4:0]  req_size;
  logic        lk_hit, act_translate, act_read, base_update;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [2:0] ADV = 3'd1, CNC = 3'd2, CCL = 3'd3, INV = 3'd4, STO = 3'd5;

  always #(CLK_P/2) clk = ~clk;

  aload_track dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_freg(req_freg), .req_paddr(req_paddr), .req_size(req_size),
    .req_nonspec(req_nonspec), .req_defer(req_defer), .req_base_upd(req_base_upd),
    .force_miss(force_miss), .lk_hit(lk_hit), .act_translate(act_translate),
    .act_read(act_read), .base_update(base_update)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Drive one request on the falling edge, check same-cycle outputs, commit on the rising edge.
  task automatic issue(logic [2:0] op, logic [6:0] fr, logic [31:0] a, logic [4:0] sz,
                       logic ns, logic df, logic bu,
                       logic e_hit, logic e_act, logic e_bu, string tag);
    @(negedge clk);
    req_valid = 1; req_op = op; req_freg = fr; req_paddr = a; req_size = sz;
    req_nonspec = ns; req_defer = df; req_base_upd = bu;
    #1;
    chk({tag, " hit"}, 32'(lk_hit), 32'(e_hit));
    chk({tag, " translate"}, 32'(act_translate), 32'(e_act));
    chk({tag, " read"}, 32'(act_read), 32'(e_act));
    chk({tag, " base_update"}, 32'(base_update), 32'(e_bu));
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  // Non-allocating presence check: keep-check on a non-speculative page.
  task automatic probe(logic [6:0] fr, logic e_hit, string tag);
    issue(CNC, fr, 32'h0, 5'd0, 1, 0, 0, e_hit, !e_hit, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; force_miss = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 idle hit", 32'(lk_hit), 0);
    chk("R1 idle act", 32'(act_read | act_translate), 0);
    chk("R1 idle base_update", 32'(base_update), 0);
    probe(7'd0, 0, "R1 empty r0");
    probe(7'd5, 0, "R1 empty r5");
  endtask

  task automatic t_adv();
    issue(ADV, 7'd3, 32'h100, 5'd8, 0, 0, 0, 0, 1, 0, "R2 adv r3");
    probe(7'd3, 1, "R2 R4 r3 present");
    probe(7'd3, 1, "R4 r3 kept after hit");
  endtask

  task automatic t_adv_noalloc();
    issue(ADV, 7'd3, 32'h100, 5'd8, 1, 0, 0, 0, 1, 0, "R3 adv nonspec");
    probe(7'd3, 0, "R3 nonspec removed r3");
    issue(ADV, 7'd4, 32'h180, 5'd4, 0, 0, 0, 0, 1, 0, "R3 adv r4");
    issue(ADV, 7'd4, 32'h180, 5'd4, 0, 1, 0, 0, 0, 0, "R3 adv deferred");
    probe(7'd4, 0, "R3 deferred leaves none");
  endtask

  task automatic t_chk_nc();
    issue(CNC, 7'd6, 32'h500, 5'd8, 0, 0, 1, 0, 1, 1, "R5 R7 keep-check miss");
    probe(7'd6, 1, "R5 miss allocated r6");
  endtask

  task automatic t_chk_clr();
    issue(CCL, 7'd6, 32'h500, 5'd8, 0, 0, 1, 1, 0, 1, "R6 R7 clear-check hit");
    probe(7'd6, 0, "R6 hit removed r6");
    issue(CCL, 7'd6, 32'h500, 5'd8, 0, 0, 1, 0, 1, 1, "R6 R7 clear-check miss");
    probe(7'd6, 0, "R6 miss allocates nothing");
  endtask

  task automatic t_force();
    issue(ADV, 7'd9, 32'h700, 5'd8, 0, 0, 0, 0, 1, 0, "R8 adv r9");
    force_miss = 1;
    probe(7'd9, 0, "R8 forced miss");
    force_miss = 0;
    probe(7'd9, 1, "R8 released hits");
  endtask

  task automatic t_inval();
    issue(INV, 7'd9, 32'h0, 5'd0, 0, 0, 0, 0, 0, 0, "R9 invalidate r9");
    probe(7'd9, 0, "R9 r9 gone");
  endtask

  task automatic t_store();
    issue(ADV, 7'd10, 32'h200, 5'd4, 0, 0, 0, 0, 1, 0, "R10 adv r10");
    issue(STO, 7'd0, 32'h204, 5'd4, 0, 0, 0, 0, 0, 0, "R10 store above");
    probe(7'd10, 1, "R10 abut above kept");
    issue(STO, 7'd0, 32'h1FC, 5'd4, 0, 0, 0, 0, 0, 0, "R10 store below");
    probe(7'd10, 1, "R10 abut below kept");
    issue(STO, 7'd0, 32'h203, 5'd1, 0, 0, 0, 0, 0, 0, "R10 store last byte");
    probe(7'd10, 0, "R10 overlap removed");
  endtask

  task automatic t_overwrite();
    issue(ADV, 7'd11, 32'h300, 5'd8, 0, 0, 0, 0, 1, 0, "R11 adv r11 first");
    issue(ADV, 7'd11, 32'h400, 5'd8, 0, 0, 0, 0, 1, 0, "R11 adv r11 again");
    issue(STO, 7'd0, 32'h300, 5'd8, 0, 0, 0, 0, 0, 0, "R11 store old range");
    probe(7'd11, 1, "R11 old address replaced");
    issue(STO, 7'd0, 32'h400, 5'd8, 0, 0, 0, 0, 0, 0, "R11 store new range");
    probe(7'd11, 0, "R11 new address tracked");
  endtask

  task automatic t_rr();
    do_reset();
    for (int k = 0; k < 8; k++)
      issue(ADV, 7'(20 + k), 32'(32'h1000 + 16 * k), 5'd8, 0, 0, 0, 0, 1, 0, "R12 fill");
    for (int k = 0; k < 8; k++)
      probe(7'(20 + k), 1, "R12 filled present");
    issue(ADV, 7'd28, 32'h2000, 5'd8, 0, 0, 0, 0, 1, 0, "R12 ninth");
    probe(7'd20, 0, "R12 oldest evicted");
    probe(7'd21, 1, "R12 second kept");
    probe(7'd28, 1, "R12 ninth present");
  endtask

  initial begin
    req_valid = 0; req_op = 0; req_freg = 0; req_paddr = 0; req_size = 0;
    req_nonspec = 0; req_defer = 0; req_base_upd = 0; force_miss = 0; rst_n = 0;
    do_reset();
    t_reset();
    t_adv();
    t_adv_noalloc();
    t_chk_nc();
    t_chk_clr();
    t_force();
    t_inval();
    t_store();
    t_overwrite();
    t_rr();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule